// File: doc/BRIEF.md
# Light-Load Conduction Mode Controller

This block drives the high-side and low-side gate enables of a synchronous buck power stage. It runs from a fast control clock and splits time into switching periods whose length follows from a 3-bit mode selector. The PWM comparator result, the zero-crossing comparator result and the mode selector arrive as digital inputs that are already synchronised. The analog comparators, the ramp and the dead-time circuits sit outside the block.

Two conduction styles are supported. In forced continuous operation a high-side pulse starts in every period, and the low-side switch carries the rest of the period. In automatic operation the low-side switch is released as soon as the zero-crossing flag reports reversing inductor current. A period is skipped when the PWM flag is low at the period boundary. Fixed-clock operation returns only after two back-to-back pulsed periods with no zero crossing. An optional anti-audible floor forces a minimum-width pulse when switching has stopped for too long.

The gate sequence is a five-state machine: `ST_IDLE` (both off), `ST_HS` (high side on), `ST_HS_REL` (one-clock gap after the high side), `ST_LS` (low side on) and `ST_LS_REL` (one-clock gap at the end of a period). Its transitions are: idle or end-gap to high side, when a pulse starts at the period boundary; high side to high-release, when the on-time ends; high-release to low side, always; low side to end-gap, at the release point two clocks before the period ends; low side to idle, on a zero crossing in automatic mode; end-gap to idle, when no pulse starts.

Top module: `lightload_cond_ctrl`

## Requirements
- R1: `mode_sel` decodes as follows: 0 = slow period, automatic, floor on; 1 = slow, automatic, floor off; 2 = fast, automatic, floor on; 3 = fast, forced continuous; 4 = fast, automatic, floor off. Codes 5 to 7 act as code 3. The slow period is `PER_SLOW` clocks and the fast period is `PER_FAST` clocks, both counted from reset.
- R2: In forced continuous operation every period starts a high-side pulse in its first clock, and `ccm_active` is 1 at all times, reset included.
- R3: A high-side pulse lasts until the first clock in which `pwm_hi` is low once `MIN_ON` clocks have passed, that clock included. It never exceeds MAX_ON = min(floor(PER*92/100), PER-3) clocks.
- R4: After every high-side pulse exactly one clock has both gates off, and then the low side turns on. The low side is off in the last clock of every period. The two gates are never on in the same clock.
- R5: In automatic operation, a `zero_cross` sampled high while the low side is on turns the low side off in the next clock, and it stays off for the rest of the period. Outside the low-side interval, and in forced operation, `zero_cross` has no effect on the gates.
- R6: In automatic operation without continuous status, a period starts a pulse only if `pwm_hi` is high in the last clock of the previous period. Otherwise both gates stay off for the whole period.
- R7: In automatic operation, `ccm_active` rises in the first clock after two consecutive periods that both had a pulse and neither had a zero crossing. While it is set, every period pulses. A period with a zero crossing or with no pulse clears it at that period's end.
- R8: With the floor on, once `FLOOR_CYC` clocks have passed with the high side off since its last on-clock, the next period starts a pulse of exactly `MIN_ON` clocks whatever `pwm_hi` does.
- R9: With the floor off, automatic operation with `pwm_hi` held low keeps both gates off indefinitely.
- R10: During reset both gates are off, and after reset the first period starts its count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Decoded mode selector, static outside reset |
| pwm_hi | input | 1 | PWM comparator result, high requests on-time |
| zero_cross | input | 1 | Inductor current zero-crossing flag |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| ccm_active | output | 1 | Continuous conduction status |

## Verification
The zero-crossing release and the scheduled end-of-period release of the low side can fall in the same clock: the bench asserts `zero_cross` in the release clock two clocks before the period ends. In that case the low side must still drop exactly once, the end gap must still precede the next high-side pulse, and the crossing must still count against continuous status, so `ccm_active` never rises even though every period pulses. Both outcomes are judged against a per-clock expectation that the bench derives from the requirements, across every mode code and several duty and crossing positions.

// File: rtl/llc_pkg.sv
package llc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HS,
        ST_HS_REL,
        ST_LS,
        ST_LS_REL
    } gate_st_e;

    typedef struct packed {
        logic fast;
        logic auto_md;
        logic sonic;
    } mode_cfg_t;

    localparam logic [2:0] MD_SLOW_AUTO_FLOOR = 3'd0;
    localparam logic [2:0] MD_SLOW_AUTO_FREE  = 3'd1;
    localparam logic [2:0] MD_FAST_AUTO_FLOOR = 3'd2;
    localparam logic [2:0] MD_FAST_FORCED     = 3'd3;
    localparam logic [2:0] MD_FAST_AUTO_FREE  = 3'd4;

endpackage

// File: rtl/llc_mode_decode.sv
module llc_mode_decode
    import llc_pkg::*;
(
    input  logic [2:0] mode_sel,
    output mode_cfg_t  cfg
);

    always_comb begin
        unique case (mode_sel)
            MD_SLOW_AUTO_FLOOR: cfg = '{fast: 1'b0, auto_md: 1'b1, sonic: 1'b1};
            MD_SLOW_AUTO_FREE:  cfg = '{fast: 1'b0, auto_md: 1'b1, sonic: 1'b0};
            MD_FAST_AUTO_FLOOR: cfg = '{fast: 1'b1, auto_md: 1'b1, sonic: 1'b1};
            MD_FAST_AUTO_FREE:  cfg = '{fast: 1'b1, auto_md: 1'b1, sonic: 1'b0};
            default:            cfg = '{fast: 1'b1, auto_md: 1'b0, sonic: 1'b0};
        endcase
    end

endmodule

// File: rtl/llc_period_timer.sv
module llc_period_timer #(
    parameter int PER_SLOW = 20,
    parameter int PER_FAST = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic at_last,
    output logic at_rel
);

    localparam int PW = $clog2(PER_SLOW + 1);
    typedef logic [PW-1:0] cnt_t;

    localparam cnt_t LAST_SLOW = cnt_t'(PER_SLOW - 1);
    localparam cnt_t LAST_FAST = cnt_t'(PER_FAST - 1);
    localparam cnt_t REL_SLOW  = cnt_t'(PER_SLOW - 2);
    localparam cnt_t REL_FAST  = cnt_t'(PER_FAST - 2);

    cnt_t cnt_q;
    cnt_t last_v;
    cnt_t rel_v;

    always_comb begin
        last_v  = fast ? LAST_FAST : LAST_SLOW;
        rel_v   = fast ? REL_FAST : REL_SLOW;
        at_last = (cnt_q >= last_v);
        at_rel  = (cnt_q == rel_v);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + cnt_t'(1);
        end
    end

endmodule

// File: rtl/llc_cond_tracker.sv
module llc_cond_tracker #(
    parameter int FLOOR_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic at_last,
    input  logic hs_on,
    input  logic zc_hit,
    output logic ccm_nx,
    output logic ccm_q,
    output logic floor_due
);

    localparam int FW = $clog2(FLOOR_CYC + 1);
    typedef logic [FW-1:0] flr_t;
    localparam flr_t FLOOR_LIM = flr_t'(FLOOR_CYC);

    logic       pulse_q;
    logic       zcs_q;
    logic [1:0] clean_q;
    logic [1:0] clean_nx;
    flr_t       floor_q;

    always_comb begin
        if (pulse_q && !zcs_q) begin
            clean_nx = (clean_q == 2'd2) ? 2'd2 : clean_q + 2'd1;
        end else begin
            clean_nx = 2'd0;
        end
        ccm_q     = (clean_q == 2'd2);
        ccm_nx    = at_last ? (clean_nx == 2'd2) : ccm_q;
        floor_due = (floor_q == FLOOR_LIM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            zcs_q   <= 1'b0;
            clean_q <= 2'd0;
        end else if (at_last) begin
            pulse_q <= 1'b0;
            zcs_q   <= 1'b0;
            clean_q <= clean_nx;
        end else begin
            pulse_q <= pulse_q | hs_on;
            zcs_q   <= zcs_q | zc_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            floor_q <= '0;
        end else if (hs_on) begin
            floor_q <= '0;
        end else if (floor_q < FLOOR_LIM) begin
            floor_q <= floor_q + flr_t'(1);
        end
    end

endmodule

// File: rtl/llc_gate_fsm.sv
module llc_gate_fsm
    import llc_pkg::*;
#(
    parameter int MIN_ON   = 2,
    parameter int MAX_SLOW = 17,
    parameter int MAX_FAST = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    input  logic auto_md,
    input  logic sonic,
    input  logic at_last,
    input  logic at_rel,
    input  logic pwm_hi,
    input  logic zero_cross,
    input  logic ccm_nx,
    input  logic floor_due,
    output logic hs_gate,
    output logic ls_gate,
    output logic zc_hit
);

    localparam int OW = $clog2(MAX_SLOW + 1);
    typedef logic [OW:0] len_t;
    localparam len_t MIN_V  = len_t'(MIN_ON);
    localparam len_t MAXS_V = len_t'(MAX_SLOW);
    localparam len_t MAXF_V = len_t'(MAX_FAST);

    gate_st_e st_q, st_nx;
    logic [OW-1:0] on_q;
    logic short_q;
    len_t len;
    len_t max_v;
    logic allow, start, short_start, hs_done;

    always_comb begin
        len         = len_t'(on_q) + len_t'(1);
        max_v       = fast ? MAXF_V : MAXS_V;
        allow       = !auto_md || ccm_nx || pwm_hi;
        start       = allow || (sonic && floor_due);
        short_start = !allow;
        hs_done     = (len >= max_v) || ((len >= MIN_V) && (!pwm_hi || short_q));
        zc_hit      = (st_q == ST_LS) && auto_md && zero_cross;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE, ST_LS_REL: st_nx = (at_last && start) ? ST_HS : ST_IDLE;
            ST_HS:              if (hs_done) st_nx = ST_HS_REL;
            ST_HS_REL:          st_nx = ST_LS;
            ST_LS: begin
                if (at_rel) begin
                    st_nx = ST_LS_REL;
                end else if (zc_hit) begin
                    st_nx = ST_IDLE;
                end
            end
            default:            st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            on_q    <= '0;
            short_q <= 1'b0;
        end else begin
            st_q <= st_nx;
            on_q <= (st_q == ST_HS && st_nx == ST_HS) ? on_q + 1'b1 : '0;
            if (st_q != ST_HS && st_nx == ST_HS) begin
                short_q <= short_start;
            end
        end
    end

    always_comb begin
        hs_gate = (st_q == ST_HS);
        ls_gate = (st_q == ST_LS);
    end

endmodule

// File: rtl/lightload_cond_ctrl.sv
module lightload_cond_ctrl
    import llc_pkg::*;
#(
    parameter int PER_SLOW  = 20,
    parameter int PER_FAST  = 10,
    parameter int MIN_ON    = 2,
    parameter int FLOOR_CYC = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       pwm_hi,
    input  logic       zero_cross,
    output logic       hs_gate,
    output logic       ls_gate,
    output logic       ccm_active
);

    localparam int RAW_SLOW = (PER_SLOW * 92) / 100;
    localparam int RAW_FAST = (PER_FAST * 92) / 100;
    localparam int MAX_SLOW = (RAW_SLOW > PER_SLOW - 3) ? PER_SLOW - 3 : RAW_SLOW;
    localparam int MAX_FAST = (RAW_FAST > PER_FAST - 3) ? PER_FAST - 3 : RAW_FAST;

    mode_cfg_t cfg;
    logic at_last, at_rel;
    logic ccm_nx, ccm_q, floor_due, zc_hit;

    llc_mode_decode dec_i (
        .mode_sel (mode_sel),
        .cfg      (cfg)
    );

    llc_period_timer #(
        .PER_SLOW (PER_SLOW),
        .PER_FAST (PER_FAST)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast    (cfg.fast),
        .at_last (at_last),
        .at_rel  (at_rel)
    );

    llc_cond_tracker #(
        .FLOOR_CYC (FLOOR_CYC)
    ) trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .at_last   (at_last),
        .hs_on     (hs_gate),
        .zc_hit    (zc_hit),
        .ccm_nx    (ccm_nx),
        .ccm_q     (ccm_q),
        .floor_due (floor_due)
    );

    llc_gate_fsm #(
        .MIN_ON   (MIN_ON),
        .MAX_SLOW (MAX_SLOW),
        .MAX_FAST (MAX_FAST)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast       (cfg.fast),
        .auto_md    (cfg.auto_md),
        .sonic      (cfg.sonic),
        .at_last    (at_last),
        .at_rel     (at_rel),
        .pwm_hi     (pwm_hi),
        .zero_cross (zero_cross),
        .ccm_nx     (ccm_nx),
        .floor_due  (floor_due),
        .hs_gate    (hs_gate),
        .ls_gate    (ls_gate),
        .zc_hit     (zc_hit)
    );

    assign ccm_active = !cfg.auto_md || ccm_q;

endmodule

// File: rtl/llc_checker.sv
module llc_checker #(
    parameter int PER_SLOW  = 20,
    parameter int PER_FAST  = 10,
    parameter int MIN_ON    = 2,
    parameter int FLOOR_CYC = 60
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_sel,
    input logic       zero_cross,
    input logic       hs_gate,
    input logic       ls_gate
);

    localparam int RS   = (PER_SLOW * 92) / 100;
    localparam int RF   = (PER_FAST * 92) / 100;
    localparam int MXS  = (RS > PER_SLOW - 3) ? PER_SLOW - 3 : RS;
    localparam int MXF  = (RF > PER_FAST - 3) ? PER_FAST - 3 : RF;
    localparam int QLIM = FLOOR_CYC + PER_SLOW;
    localparam int RW   = $clog2(PER_SLOW + 2);
    localparam int QW   = $clog2(QLIM + 2);

    logic [RW-1:0] run_q;
    logic [QW-1:0] quiet_q;
    logic slow_m, auto_m, floor_m;
    logic [RW-1:0] max_m;

    always_comb begin
        slow_m  = (mode_sel == 3'd0) || (mode_sel == 3'd1);
        auto_m  = slow_m || (mode_sel == 3'd2) || (mode_sel == 3'd4);
        floor_m = (mode_sel == 3'd0) || (mode_sel == 3'd2);
        max_m   = slow_m ? RW'(MXS) : RW'(MXF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            quiet_q <= '0;
        end else begin
            if (hs_gate) begin
                run_q   <= (run_q == {RW{1'b1}}) ? run_q : run_q + 1'b1;
                quiet_q <= '0;
            end else begin
                run_q   <= '0;
                quiet_q <= (quiet_q == {QW{1'b1}}) ? quiet_q : quiet_q + 1'b1;
            end
        end
    end

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R4
    hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_gate && !$past(hs_gate)) |-> !$past(ls_gate));

    // R4
    ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_gate && !$past(ls_gate)) |-> !$past(hs_gate));

    // R3
    max_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_gate |-> (run_q < max_m));

    // R3
    min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_gate && run_q != '0) |-> (run_q >= RW'(MIN_ON)));

    // R5
    zc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_gate && zero_cross && auto_m) |=> !ls_gate);

    // R8
    floor_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        floor_m |-> (quiet_q <= QW'(QLIM)));

endmodule

bind lightload_cond_ctrl llc_checker #(
    .PER_SLOW  (PER_SLOW),
    .PER_FAST  (PER_FAST),
    .MIN_ON    (MIN_ON),
    .FLOOR_CYC (FLOOR_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .zero_cross (zero_cross),
    .hs_gate    (hs_gate),
    .ls_gate    (ls_gate)
);

// File: tb/lightload_cond_ctrl_tb_top.sv
`timescale 1ns/1ps
module lightload_cond_ctrl_tb_top;

    localparam int PS  = 20;
    localparam int PF  = 10;
    localparam int MN  = 2;
    localparam int FLR = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic pwm_hi = 1'b0;
    logic zero_cross = 1'b0;
    logic hs_gate, ls_gate, ccm_active;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lightload_cond_ctrl #(
        .PER_SLOW (PS),
        .PER_FAST (PF),
        .MIN_ON   (MN),
        .FLOOR_CYC(FLR)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .pwm_hi     (pwm_hi),
        .zero_cross (zero_cross),
        .hs_gate    (hs_gate),
        .ls_gate    (ls_gate),
        .ccm_active (ccm_active)
    );

    function automatic int per_of(input int md);
        return (md == 0 || md == 1) ? PS : PF;
    endfunction
    function automatic bit forced_of(input int md);
        return !(md == 0 || md == 1 || md == 2 || md == 4);
    endfunction
    function automatic bit floor_of(input int md);
        return (md == 0 || md == 2);
    endfunction
    function automatic int maxon_of(input int md);
        int p = per_of(md);
        int r = (p * 92) / 100;
        return (r > p - 3) ? p - 3 : r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected behaviour, tracked clock by clock from the requirements
    int m_ph, m_len, m_quiet, m_clean;
    bit m_hs, m_ls, m_gap, m_sp, m_sz, m_short;
    int t_per;
    bit t_last, t_forced, t_zh, t_sp, t_sz, t_cn, t_start, t_allow, t_end;
    int t_cl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 0; m_len <= 0; m_quiet <= 0; m_clean <= 0;
            m_hs <= 0; m_ls <= 0; m_gap <= 0; m_sp <= 0; m_sz <= 0; m_short <= 0;
        end else begin
            t_per    = per_of(int'(mode_sel));
            t_forced = forced_of(int'(mode_sel));
            t_last   = (m_ph == t_per - 1);
            t_zh     = m_ls && !t_forced && zero_cross;
            t_sp     = m_sp || m_hs;
            t_sz     = m_sz || t_zh;
            t_cl     = (t_sp && !t_sz) ? ((m_clean >= 2) ? 2 : m_clean + 1) : 0;
            t_cn     = t_last ? (t_cl == 2) : (m_clean == 2);
            t_allow  = t_forced || t_cn || pwm_hi;
            t_start  = t_allow || (floor_of(int'(mode_sel)) && m_quiet >= FLR);
            m_ph    <= t_last ? 0 : m_ph + 1;
            if (t_last) begin
                m_clean <= t_cl; m_sp <= 0; m_sz <= 0;
            end else begin
                m_sp <= t_sp; m_sz <= t_sz;
            end
            m_quiet <= m_hs ? 0 : ((m_quiet >= FLR) ? FLR : m_quiet + 1);
            if (m_hs) begin
                t_end = (m_len + 1 >= maxon_of(int'(mode_sel))) ||
                        ((m_len + 1 >= MN) && (!pwm_hi || m_short));
                m_len <= m_len + 1;
                if (t_end) begin m_hs <= 0; m_gap <= 1; end
            end else if (m_gap) begin
                m_gap <= 0; m_ls <= 1;
            end else if (m_ls) begin
                if (m_ph == t_per - 2 || t_zh) m_ls <= 0;
            end else if (t_last && t_start) begin
                m_hs <= 1; m_len <= 0; m_short <= !t_allow;
            end
        end
    end

    int first_rise, second_rise, first_hs_w, first_ls_w, ccm_rise, hs_cnt;

    task automatic run_cfg(input int md, input int d, input int z, input int act, input int ncyc);
        int per = per_of(md);
        bit prev_hs = 0, prev_ls = 0, hs_done_w = 0, ls_done_w = 0;
        int hw = 0, lw = 0;
        mode_sel = 3'(md); pwm_hi = 0; zero_cross = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        // R10 reset state; R2 status in forced operation
        check("R10 hs_gate in reset", int'(hs_gate), 0);
        check("R10 ls_gate in reset", int'(ls_gate), 0);
        check("R2 R7 ccm_active in reset", int'(ccm_active), int'(forced_of(md)));
        rst_n = 1;
        first_rise = -1; second_rise = -1; first_hs_w = -1; first_ls_w = -1;
        ccm_rise = -1; hs_cnt = 0;
        for (int k = 0; k < ncyc; k++) begin
            int ph = k % per;
            int pidx = k / per;
            bit active = (act != 0) && (pidx % (act == 0 ? 1 : act) == 0);
            pwm_hi = active && (ph < d || ph == per - 1);
            zero_cross = (ph == z);
            @(negedge clk);
            check("R3 R6 R8 R9 hs_gate", int'(hs_gate), int'(m_hs));
            check("R4 R5 ls_gate", int'(ls_gate), int'(m_ls));
            check("R7 ccm_active", int'(ccm_active), int'(!forced_of(md) ? (m_clean == 2) : 1'b1));
            if (hs_gate) begin
                hs_cnt++;
                if (!prev_hs) begin
                    if (first_rise < 0) first_rise = k + 1;
                    else if (second_rise < 0) second_rise = k + 1;
                end
                if (!hs_done_w) hw++;
            end else if (prev_hs && !hs_done_w) begin
                hs_done_w = 1; first_hs_w = hw;
            end
            if (ls_gate) begin
                if (!ls_done_w) lw++;
            end else if (prev_ls && !ls_done_w) begin
                ls_done_w = 1; first_ls_w = lw;
            end
            if (ccm_active && ccm_rise < 0) ccm_rise = k + 1;
            prev_hs = hs_gate; prev_ls = ls_gate;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Sweep: every mode code, duty, crossing position, activity pattern
        for (int md = 0; md < 8; md++) begin
            for (int di = 0; di < 4; di++) begin
                for (int zi = 0; zi < 3; zi++) begin
                    for (int act = 0; act < 4; act += (act == 0 ? 1 : 2)) begin
                        int p = per_of(md);
                        int d = (di == 0) ? 0 : (di == 1) ? 3 : (di == 2) ? 5 : p;
                        int z = (zi == 0) ? p - 5 : (zi == 1) ? p - 2 : 999;
                        run_cfg(md, d, z, act, 12 * PS);
                    end
                end
            end
        end

        // R1 period length per code, measured with pwm always high
        for (int md = 0; md < 8; md++) begin
            run_cfg(md, per_of(md), 999, 1, 6 * PS);
            check("R1 rise spacing", second_rise - first_rise, per_of(md));
        end

        // R2 forced: pulse every period, minimum width with pwm low
        run_cfg(3, 0, 999, 1, 4 * PF);
        check("R2 first forced rise", first_rise, PF);
        check("R2 second forced rise", second_rise, 2 * PF);
        check("R3 min width", first_hs_w, MN);

        // R3 maximum duty clamp
        run_cfg(3, PF, 999, 1, 4 * PF);
        check("R3 max width fast", first_hs_w, maxon_of(3));
        run_cfg(0, PS, 999, 1, 4 * PS);
        check("R3 max width slow", first_hs_w, maxon_of(0));

        // R5 crossing release, and no effect in forced operation
        run_cfg(0, 3, 15, 1, 3 * PS);
        check("R5 ls width released by crossing", first_ls_w, 15 - 3 - 1);
        run_cfg(3, 3, 5, 1, 3 * PF);
        check("R5 ls width forced ignores crossing", first_ls_w, PF - 3 - 3);

        // R6 skipped periods
        run_cfg(0, 5, 999, 3, 6 * PS);
        check("R6 first pulse", first_rise, PS);
        check("R6 next pulse after skips", second_rise, 4 * PS);

        // R7 entry after two clean periods, crossing blocks it
        run_cfg(0, PS, 999, 1, 6 * PS);
        check("R7 ccm rise slow", ccm_rise, 3 * PS);
        run_cfg(2, PF, 999, 1, 6 * PF);
        check("R7 ccm rise fast", ccm_rise, 3 * PF);
        run_cfg(0, PS, PS - 2, 1, 8 * PS);
        check("R7 crossing at release keeps ccm low", ccm_rise, -1);

        // R8 anti-audible floor
        run_cfg(0, 0, 999, 0, 6 * PS);
        check("R8 forced pulse time", first_rise, ((FLR + 1 + PS - 1) / PS) * PS);
        check("R8 forced pulse width", first_hs_w, MN);

        // R9 no floor
        run_cfg(1, 0, 999, 0, 20 * PS);
        check("R9 no pulses", hs_cnt, 0);
        run_cfg(4, 0, 999, 0, 30 * PF);
        check("R9 no pulses fast", hs_cnt, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule